// File: doc/BRIEF.md
# Receive Byte Queue with Selectable Fill Thresholds

This block sits between a serial receiver and the host bus. Each character the receiver completes is written into a 16-entry first-in first-out store together with three status flags: parity error, framing error and break. The host reads characters from the head of the queue. The data byte and the flags of the oldest entry are always visible at the read port.

The block keeps a fill count and compares it with one of four thresholds that software selects. Two outputs follow from that comparison. The first is a data-available interrupt request, which is high while the count is at or above the threshold. The second is a DMA receive-ready signal. It turns on when the threshold is reached and stays on until the queue has been drained completely.

An aggregate error output is high while any stored character carries a flag. A synchronous flush input empties the queue. The flush acts only on the storage side; the receiver feeding the block is left untouched.

Top module: `rxq_fifo`

## Requirements
- R1: After reset, and in the cycle after a flush, the block reports count 0, empty 1, data_avail 0, rx_ready 0 and err_any 0.
- R2: Reads return characters in the order they were written, and each comes with its own parity (rd_perr), framing (rd_ferr) and break (rd_brk) flags. While empty is 0, rd_data and the three flags show the head entry without any read strobe.
- R3: The count goes up by one for each accepted write, and full is 1 at 16 entries. A write while full with no read in the same cycle is discarded: wr_drop is 1 in that cycle, and the count and stored contents stay as they were.
- R4: A read and a write in the same cycle on a non-empty queue leave the count unchanged and advance the head. A read while empty is ignored.
- R5: trig_sel codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14 entries. data_avail is 1 exactly when the count is at or above the selected threshold.
- R6: rx_ready becomes 1 in the same cycle the count reaches the threshold. It stays 1 as reads bring the count below the threshold, and it returns to 0 only when the count reaches 0.
- R7: err_any is 1 while at least one stored entry has any of its three flags set. It returns to 0 once the last such entry has been read out.
- R8: A flush clears the pointers and the count, and a write in the same cycle is discarded. A write in the following cycle is stored and appears at the head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous queue flush (software reset) |
| trig_sel | input | 2 | Threshold select: 00=1, 01=4, 10=8, 11=14 |
| wr_en | input | 1 | Receiver write strobe |
| wr_data | input | DATA_W | Received character |
| wr_perr | input | 1 | Parity error flag of the character |
| wr_ferr | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | Host read strobe, pops the head entry |
| rd_data | output | DATA_W | Head entry character |
| rd_perr | output | 1 | Head entry parity error flag |
| rd_ferr | output | 1 | Head entry framing error flag |
| rd_brk | output | 1 | Head entry break flag |
| count | output | CNT_W | Number of stored entries |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Queue holds DEPTH entries |
| wr_drop | output | 1 | A write was discarded this cycle |
| data_avail | output | 1 | Interrupt request: count at or above threshold |
| rx_ready | output | 1 | DMA receive-ready, set at threshold, cleared on empty |
| err_any | output | 1 | Some stored entry carries a flag |

## Verification
The bench builds the block with its default parameters, DEPTH=16 and DATA_W=8. At this depth every threshold (1, 4, 8 and 14) and the full boundary can be reached in a few dozen cycles. The bench can therefore sweep all four trigger codes, fill the queue to overflow, and follow rx_ready as the count drops from above the threshold down to empty. With 8-bit data, each entry in the overflow test gets a distinct pattern, so a dropped write that overwrote a stored entry would show up as a wrong value.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int FLAG_W = 3;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_flags_t;

  // threshold in entries for a two-bit select, scaled to the queue depth
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction

  function automatic logic any_flag(input rxq_flags_t f);
    return f.brk | f.ferr | f.perr;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] wr_entry,
  output logic [ENTRY_W-1:0] head_entry
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wp_q, rp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else if (flush) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + PTR_W'(1);
      if (pop)  rp_q <= rp_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_entry;
  end

  assign head_entry = mem[rp_q];
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [1:0]       trig_sel,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             data_avail,
  output logic             rx_ready
);
  logic [CNT_W-1:0] cnt_q, cnt_next, lvl;
  logic             rdy_q, rdy_next;

  assign lvl      = CNT_W'(rxq_pkg::trig_level(trig_sel, DEPTH));
  assign cnt_next = flush ? '0 : cnt_q + CNT_W'(push) - CNT_W'(pop);

  always_comb begin
    if (flush || cnt_next == '0) rdy_next = 1'b0;
    else if (cnt_next >= lvl)    rdy_next = 1'b1;
    else                         rdy_next = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_next;
      rdy_q <= rdy_next;
    end
  end

  assign count      = cnt_q;
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign data_avail = (cnt_q >= lvl);
  assign rx_ready   = rdy_q;
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
  parameter int CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic push_flagged,
  input  logic pop_flagged,
  output logic err_any
);
  logic [CNT_W-1:0] ecnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ecnt_q <= '0;
    else if (flush) ecnt_q <= '0;
    else            ecnt_q <= ecnt_q + CNT_W'(push_flagged) - CNT_W'(pop_flagged);
  end

  assign err_any = (ecnt_q != '0);
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic [1:0]                    trig_sel,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          wr_perr,
  input  logic                          wr_ferr,
  input  logic                          wr_brk,
  input  logic                          rd_en,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_perr,
  output logic                          rd_ferr,
  output logic                          rd_brk,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          empty,
  output logic                          full,
  output logic                          wr_drop,
  output logic                          data_avail,
  output logic                          rx_ready,
  output logic                          err_any
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = DATA_W + rxq_pkg::FLAG_W;

  rxq_pkg::rxq_flags_t wr_flags, head_flags;
  logic [ENTRY_W-1:0]  wr_entry, head_entry;
  logic                push, pop;

  assign wr_flags = '{brk: wr_brk, ferr: wr_ferr, perr: wr_perr};
  assign wr_entry = {wr_flags, wr_data};

  // a full queue still takes a write when a read frees a slot in the same cycle
  assign push    = wr_en && !flush && (!full || rd_en);
  assign pop     = rd_en && !flush && !empty;
  assign wr_drop = wr_en && !flush && full && !rd_en;

  rxq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wr_entry(wr_entry), .head_entry(head_entry)
  );

  rxq_level #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .trig_sel(trig_sel), .count(count), .full(full), .empty(empty),
    .data_avail(data_avail), .rx_ready(rx_ready)
  );

  rxq_errtrack #(.CNT_W(CNT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_flagged(push && rxq_pkg::any_flag(wr_flags)),
    .pop_flagged(pop && rxq_pkg::any_flag(head_flags)),
    .err_any(err_any)
  );

  assign head_flags = head_entry[ENTRY_W-1:DATA_W];
  assign rd_data    = head_entry[DATA_W-1:0];
  assign rd_perr    = head_flags.perr;
  assign rd_ferr    = head_flags.ferr;
  assign rd_brk     = head_flags.brk;
endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             rd_en,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] count,
  input logic             empty,
  input logic             data_avail,
  input logic             rx_ready,
  input logic             err_any,
  input logic             wr_drop
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!rx_ready && !err_any && !data_avail));

  // R3
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> (count == $past(count)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ((count == $past(count)) || (count == $past(count) + CNT_W'(1))
               || (count + CNT_W'(1) == $past(count))));

  // R5
  avail_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_avail && $stable(trig_sel)) |-> rx_ready);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !flush && !(rd_en && count == CNT_W'(1))) |=> rx_ready);

  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && empty));
endmodule

bind rxq_fifo rxq_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rxq_fifo_tb.sv
module rxq_fifo_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic wr_perr = 1'b0, wr_ferr = 1'b0, wr_brk = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, empty, full, wr_drop, data_avail, rx_ready, err_any;
  logic [CW-1:0] count;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [10:0] model[$];   // {brk, ferr, perr, data}

  rxq_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .trig_sel(trig_sel),
    .wr_en(wr_en), .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr), .wr_brk(wr_brk),
    .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .count(count), .empty(empty), .full(full), .wr_drop(wr_drop),
    .data_avail(data_avail), .rx_ready(rx_ready), .err_any(err_any)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int thr(input int s);
    case (s)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    wr_en = 1'b1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f;
    step();
    wr_en = 1'b0; {wr_brk, wr_ferr, wr_perr} = 3'b000;
    if (model.size() < DEPTH) model.push_back({f, d});
  endtask

  task automatic pop_chk(input string req);
    logic [10:0] e;
    e = model.pop_front();
    chk(req, "head data", rd_data, e[7:0]);
    chk(req, "head flags", {rd_brk, rd_ferr, rd_perr}, e[10:8]);
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    step();
    flush = 1'b0;
    model.delete();
  endtask

  task automatic t_reset();
    chk("R1", "count at reset", count, 0);
    chk("R1", "empty at reset", empty, 1);
    chk("R1", "data_avail at reset", data_avail, 0);
    chk("R1", "rx_ready at reset", rx_ready, 0);
    chk("R1", "err_any at reset", err_any, 0);
  endtask

  task automatic t_order();
    push(8'h11, 3'b000); push(8'h22, 3'b001); push(8'h33, 3'b010);
    push(8'h44, 3'b100); push(8'h55, 3'b111);
    chk("R3", "count after 5 writes", count, 5);
    for (int i = 0; i < 5; i++) pop_chk("R2");
    chk("R2", "empty after draining", empty, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(8'(i * 3 + 1), (i == 5) ? 3'b001 : 3'b000);
    chk("R3", "full at 16", full, 1);
    chk("R3", "count at 16", count, 16);
    wr_en = 1'b1; wr_data = 8'hEE;
    #1;
    chk("R3", "wr_drop on write while full", wr_drop, 1);
    step();
    wr_en = 1'b0;
    chk("R3", "count after dropped write", count, 16);
    for (int i = 0; i < DEPTH; i++) pop_chk("R3");
    chk("R3", "empty after drain", empty, 1);
  endtask

  task automatic t_simul();
    push(8'hA1, 3'b000); push(8'hB2, 3'b000);
    chk("R4", "head before simultaneous op", rd_data, 8'hA1);
    wr_en = 1'b1; wr_data = 8'hC3; rd_en = 1'b1;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
    void'(model.pop_front());
    model.push_back({3'b000, 8'hC3});
    chk("R4", "count after read+write", count, 2);
    chk("R4", "head advanced", rd_data, 8'hB2);
    pop_chk("R4"); pop_chk("R4");
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R4", "count after read on empty", count, 0);
    chk("R4", "empty after read on empty", empty, 1);
    push(8'hD4, 3'b000);
    chk("R4", "head after empty read then write", rd_data, 8'hD4);
    pop_chk("R4");
  endtask

  task automatic t_trig();
    for (int s = 0; s < 4; s++) begin
      do_flush();
      trig_sel = 2'(s);
      #1;
      chk("R5", "data_avail empty", data_avail, 0);
      for (int k = 1; k <= DEPTH; k++) begin
        push(8'(k), 3'b000);
        chk("R5", $sformatf("data_avail sel=%0d count=%0d", s, k), data_avail, (k >= thr(s)) ? 1 : 0);
      end
    end
    do_flush();
  endtask

  task automatic t_rdy();
    trig_sel = 2'd1;
    push(8'h01, 3'b000); push(8'h02, 3'b000); push(8'h03, 3'b000);
    chk("R6", "rx_ready below threshold", rx_ready, 0);
    push(8'h04, 3'b000);
    chk("R6", "rx_ready at threshold", rx_ready, 1);
    chk("R5", "data_avail at threshold", data_avail, 1);
    for (int i = 0; i < 3; i++) pop_chk("R6");
    chk("R6", "rx_ready held at count 1", rx_ready, 1);
    chk("R5", "data_avail below threshold", data_avail, 0);
    pop_chk("R6");
    chk("R6", "rx_ready cleared on empty", rx_ready, 0);
    push(8'h05, 3'b000);
    chk("R6", "rx_ready stays low below threshold", rx_ready, 0);
    pop_chk("R6");
  endtask

  task automatic t_err();
    push(8'h10, 3'b000); push(8'h20, 3'b001); push(8'h30, 3'b000);
    chk("R7", "err_any with parity entry", err_any, 1);
    pop_chk("R7");
    chk("R7", "err_any before flagged read", err_any, 1);
    pop_chk("R7");
    chk("R7", "err_any after flagged read", err_any, 0);
    pop_chk("R7");
    push(8'h40, 3'b010); push(8'h50, 3'b100);
    chk("R7", "err_any framing+break", err_any, 1);
    pop_chk("R7");
    chk("R7", "err_any one break left", err_any, 1);
    pop_chk("R7");
    chk("R7", "err_any all read", err_any, 0);
  endtask

  task automatic t_flush();
    trig_sel = 2'd0;
    for (int i = 0; i < 5; i++) push(8'(8'h60 + i), (i == 2) ? 3'b010 : 3'b000);
    chk("R8", "rx_ready before flush", rx_ready, 1);
    chk("R8", "err_any before flush", err_any, 1);
    do_flush();
    chk("R1", "count after flush", count, 0);
    chk("R1", "empty after flush", empty, 1);
    chk("R1", "rx_ready after flush", rx_ready, 0);
    chk("R1", "err_any after flush", err_any, 0);
    chk("R1", "data_avail after flush", data_avail, 0);
    push(8'hA5, 3'b000);
    chk("R8", "count after post-flush write", count, 1);
    chk("R8", "head after flush", rd_data, 8'hA5);
    pop_chk("R8");
    flush = 1'b1; wr_en = 1'b1; wr_data = 8'h5A;
    step();
    flush = 1'b0; wr_en = 1'b0;
    chk("R8", "write during flush discarded", count, 0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-requirements act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_order();
    t_full();
    t_simul();
    t_trig();
    t_rdy();
    t_err();
    t_flush();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule